// File: doc/BRIEF.md
# Variable Count Shifter with Flag Write Rules

This block shifts a 32-bit operand by a variable amount and reports the sign, zero, carry and overflow flags that the shift produces. It can shift left, shift right with zero fill, or shift right with sign fill. A 3-bit sub-operation code selects the shift. The amount is taken from the low five bits of a separate count word. Each flag comes with a write-enable bit, so an integer core can tell which architectural flags to update and which to keep. Some of those decisions depend on the masked count being zero or one.

A request is presented with `req_valid` and is captured on the rising clock edge. The result, the flag values, the flag write mask, a result write-enable and an illegal-code indication come out of registers one cycle later. A two-state controller tracks whether the output registers hold a fresh result. State `ST_IDLE` means nothing is pending. State `ST_RESULT` means the registers hold the answer to the previous cycle's request. Transition `T_ISSUE` goes to `ST_RESULT` whenever `req_valid` is high. Transition `T_DRAIN` goes to `ST_IDLE` when it is low. `ST_RESULT` keeps itself on back-to-back requests.

Top module: `shf_unit`

## Requirements
- R1: Only bits [4:0] of `count_src` form the shift amount (0 to 31). Upper bits have no effect on any output.
- R2: The sub-operation codes are 4 (shift left), 5 (logical right) and 7 (arithmetic right). Any other code sets `out_illegal`, clears `out_res_wr` and `out_flag_wr`, and returns the operand unchanged on `out_result`.
- R3: The result is zero-filled for codes 4 and 5 and sign-filled for code 7. For example, 0xFFFFFFFD shifted right by 1 gives 0xFFFFFFFE with code 7 and 0x7FFFFFFE with code 5. 13 shifted left by 1 gives 0x0000001A.
- R4: For a left shift with a non-zero amount, the sign, zero and carry flags are written. Sign is result bit 31. Zero is set for a zero result. Carry is the last bit pushed out of bit 31.
- R5: For codes 4 and 5 with an amount of exactly 1, overflow is written as operand bit 31 XOR bit 30. For code 7 with an amount of 1, overflow is written as 0. For any other amount the overflow write bit is 0.
- R6: For a logical right shift with a non-zero amount, sign is written as 0 and zero is written from the result. For both right shifts the carry write bit stays 0. The arithmetic right shift writes sign as result bit 31 and writes zero from the result.
- R7: An amount of 0 after masking writes nothing: `out_res_wr` = 0, `out_flag_wr` = 0, and `out_result` equals the operand.
- R8: Outputs are valid exactly one cycle after a request. In a cycle with no preceding request, `out_valid`, `out_res_wr`, `out_illegal` and `out_flag_wr` are all 0.
- R9: While reset is held, all outputs are 0.
- R10: Flag vectors use bit 0 = sign, bit 1 = zero, bit 2 = carry, bit 3 = overflow. A flag value bit whose write bit is 0 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| sub_op | input | 3 | Shift selection code |
| operand | input | 32 | Value to shift |
| count_src | input | 32 | Count word; low five bits used |
| out_valid | output | 1 | Output registers hold a fresh result |
| out_result | output | 32 | Shifted value (operand if not written) |
| out_res_wr | output | 1 | Result should be written back |
| out_flag_val | output | 4 | Flag values {OF,CF,ZF,SF} |
| out_flag_wr | output | 4 | Flag write enables, same bit order |
| out_illegal | output | 1 | Sub-operation code was not 4, 5 or 7 |

## Verification
Every output is due exactly one rising edge after the request that causes it. The bench drives each request on a falling edge and compares all outputs at the next falling edge, half a period after the capturing edge. The idle behaviour is checked one falling edge after `req_valid` drops. The reset values are read while reset is still asserted, before the first request.

// File: rtl/shf_pkg.sv
package shf_pkg;

    localparam logic [2:0] SUBOP_SHL = 3'd4;
    localparam logic [2:0] SUBOP_SHR = 3'd5;
    localparam logic [2:0] SUBOP_SAR = 3'd7;

    localparam int FLAG_N = 4;
    localparam int FL_SF  = 0;
    localparam int FL_ZF  = 1;
    localparam int FL_CF  = 2;
    localparam int FL_OF  = 3;

    typedef enum logic [1:0] {
        K_SHL = 2'd0,
        K_SHR = 2'd1,
        K_SAR = 2'd2,
        K_BAD = 2'd3
    } shift_kind_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } shf_state_e;

endpackage

// File: rtl/shf_decode.sv
module shf_decode
    import shf_pkg::*;
(
    input  logic [2:0]  sub_op,
    output shift_kind_e kind
);
    always_comb begin
        case (sub_op)
            SUBOP_SHL: kind = K_SHL;
            SUBOP_SHR: kind = K_SHR;
            SUBOP_SAR: kind = K_SAR;
            default:   kind = K_BAD;
        endcase
    end
endmodule

// File: rtl/shf_count_mask.sv
module shf_count_mask #(
    parameter int CNT_SRC_W = 32,
    parameter int CNT_W     = 5
) (
    input  logic [CNT_SRC_W-1:0] count_src,
    output logic [CNT_W-1:0]     amount,
    output logic                 amt_zero,
    output logic                 amt_one
);
    localparam logic [CNT_W-1:0] AMT_ONE = CNT_W'(1);

    logic unused_hi_bits;

    assign amount         = count_src[CNT_W-1:0];
    assign amt_zero       = (amount == '0);
    assign amt_one        = (amount == AMT_ONE);
    assign unused_hi_bits = ^count_src[CNT_SRC_W-1:CNT_W];
endmodule

// File: rtl/shf_barrel.sv
module shf_barrel
    import shf_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] operand,
    input  logic [CNT_W-1:0]  amount,
    input  shift_kind_e       kind,
    output logic [DATA_W-1:0] res,
    output logic              carry_left
);
    localparam int EXT_W = DATA_W + 1;

    // left path is one bit wider so the last bit pushed out survives
    logic [EXT_W-1:0]  lv [0:CNT_W];
    logic [DATA_W-1:0] rv [0:CNT_W];
    logic              fill;

    assign fill  = (kind == K_SAR) && operand[DATA_W-1];
    assign lv[0] = {1'b0, operand};
    assign rv[0] = operand;

    for (genvar s = 0; s < CNT_W; s++) begin : g_stage
        localparam int SH = 1 << s;
        assign lv[s+1] = amount[s] ? (lv[s] << SH) : lv[s];
        assign rv[s+1] = amount[s] ? {{SH{fill}}, rv[s][DATA_W-1:SH]} : rv[s];
    end

    assign res        = (kind == K_SHL) ? lv[CNT_W][DATA_W-1:0] : rv[CNT_W];
    assign carry_left = lv[CNT_W][DATA_W];
endmodule

// File: rtl/shf_flags.sv
module shf_flags
    import shf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  shift_kind_e       kind,
    input  logic [DATA_W-1:0] operand,
    input  logic [DATA_W-1:0] res,
    input  logic              carry_left,
    input  logic              amt_zero,
    input  logic              amt_one,
    output logic [FLAG_N-1:0] flag_val,
    output logic [FLAG_N-1:0] flag_wr,
    output logic              res_wr,
    output logic              illegal
);
    logic res_is_zero;
    logic top_pair_differs;

    assign res_is_zero      = (res == '0);
    assign top_pair_differs = operand[DATA_W-1] ^ operand[DATA_W-2];

    always_comb begin
        flag_val = '0;
        flag_wr  = '0;
        res_wr   = 1'b0;
        illegal  = 1'b0;
        unique case (kind)
            K_SHL: begin
                if (!amt_zero) begin
                    res_wr          = 1'b1;
                    flag_wr[FL_SF]  = 1'b1;
                    flag_val[FL_SF] = res[DATA_W-1];
                    flag_wr[FL_ZF]  = 1'b1;
                    flag_val[FL_ZF] = res_is_zero;
                    flag_wr[FL_CF]  = 1'b1;
                    flag_val[FL_CF] = carry_left;
                    if (amt_one) begin
                        flag_wr[FL_OF]  = 1'b1;
                        flag_val[FL_OF] = top_pair_differs;
                    end
                end
            end
            K_SHR: begin
                if (!amt_zero) begin
                    res_wr          = 1'b1;
                    flag_wr[FL_SF]  = 1'b1;
                    flag_wr[FL_ZF]  = 1'b1;
                    flag_val[FL_ZF] = res_is_zero;
                    if (amt_one) begin
                        flag_wr[FL_OF]  = 1'b1;
                        flag_val[FL_OF] = top_pair_differs;
                    end
                end
            end
            K_SAR: begin
                if (!amt_zero) begin
                    res_wr          = 1'b1;
                    flag_wr[FL_SF]  = 1'b1;
                    flag_val[FL_SF] = res[DATA_W-1];
                    flag_wr[FL_ZF]  = 1'b1;
                    flag_val[FL_ZF] = res_is_zero;
                    if (amt_one) begin
                        flag_wr[FL_OF] = 1'b1;
                    end
                end
            end
            K_BAD: begin
                illegal = 1'b1;
            end
        endcase
    end

    // R10: a value bit never appears without its write bit
    always_comb begin
        p_val_under_mask_r10: assert ((flag_val & ~flag_wr) == '0);
    end
endmodule

// File: rtl/shf_unit.sv
module shf_unit
    import shf_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int CNT_SRC_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [2:0]           sub_op,
    input  logic [DATA_W-1:0]    operand,
    input  logic [CNT_SRC_W-1:0] count_src,
    output logic                 out_valid,
    output logic [DATA_W-1:0]    out_result,
    output logic                 out_res_wr,
    output logic [FLAG_N-1:0]    out_flag_val,
    output logic [FLAG_N-1:0]    out_flag_wr,
    output logic                 out_illegal
);
    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] AMT_ONE = CNT_W'(1);

    shift_kind_e       kind;
    logic [CNT_W-1:0]  amount;
    logic              amt_zero;
    logic              amt_one;
    logic [DATA_W-1:0] sh_res;
    logic              carry_left;
    logic [FLAG_N-1:0] nx_flag_val;
    logic [FLAG_N-1:0] nx_flag_wr;
    logic              nx_res_wr;
    logic              nx_illegal;
    shf_state_e        state_q;
    shf_state_e        state_d;

    shf_decode u_decode (
        .sub_op (sub_op),
        .kind   (kind)
    );

    shf_count_mask #(
        .CNT_SRC_W (CNT_SRC_W),
        .CNT_W     (CNT_W)
    ) u_count (
        .count_src (count_src),
        .amount    (amount),
        .amt_zero  (amt_zero),
        .amt_one   (amt_one)
    );

    shf_barrel #(
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) u_barrel (
        .operand    (operand),
        .amount     (amount),
        .kind       (kind),
        .res        (sh_res),
        .carry_left (carry_left)
    );

    shf_flags #(
        .DATA_W (DATA_W)
    ) u_flags (
        .kind       (kind),
        .operand    (operand),
        .res        (sh_res),
        .carry_left (carry_left),
        .amt_zero   (amt_zero),
        .amt_one    (amt_one),
        .flag_val   (nx_flag_val),
        .flag_wr    (nx_flag_wr),
        .res_wr     (nx_res_wr),
        .illegal    (nx_illegal)
    );

    // controller: T_ISSUE on a request, T_DRAIN otherwise
    always_comb begin
        unique case (state_q)
            ST_IDLE:   state_d = req_valid ? ST_RESULT : ST_IDLE;
            ST_RESULT: state_d = req_valid ? ST_RESULT : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !req_valid) begin
            out_result   <= '0;
            out_res_wr   <= 1'b0;
            out_flag_val <= '0;
            out_flag_wr  <= '0;
            out_illegal  <= 1'b0;
        end else begin
            out_result   <= nx_res_wr ? sh_res : operand;
            out_res_wr   <= nx_res_wr;
            out_flag_val <= nx_flag_val;
            out_flag_wr  <= nx_flag_wr;
            out_illegal  <= nx_illegal;
        end
    end

    assign out_valid = (state_q == ST_RESULT);

    // R8: a request yields a valid output on the next edge
    p_valid_next_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);

    // R8: nothing is written while no fresh result is held
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_flag_wr == '0) && !out_res_wr && !out_illegal);

    // R2: an illegal code never requests a write
    p_illegal_nowrite_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_illegal |-> !out_res_wr && (out_flag_wr == '0));

    // R7: a masked amount of zero passes the operand and writes nothing
    p_zero_amount_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && count_src[CNT_W-1:0] == '0) |=>
        (out_result == $past(operand)) && (out_flag_wr == '0) && !out_res_wr);

    // R5: overflow is written only for an amount of exactly one
    p_of_only_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && count_src[CNT_W-1:0] != AMT_ONE) |=> !out_flag_wr[FL_OF]);

    // R6: logical right writes sign as 0 and never writes carry
    p_shr_sign_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && sub_op == SUBOP_SHR && count_src[CNT_W-1:0] != '0) |=>
        out_flag_wr[FL_SF] && !out_flag_val[FL_SF] && !out_flag_wr[FL_CF]);
endmodule

// File: tb/shf_unit_tb_top.sv
module shf_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [2:0]  sub_op;
    logic [31:0] operand;
    logic [31:0] count_src;
    logic        out_valid;
    logic [31:0] out_result;
    logic        out_res_wr;
    logic [3:0]  out_flag_val;
    logic [3:0]  out_flag_wr;
    logic        out_illegal;

    int checks   = 0;
    int failures = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    shf_unit dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .sub_op       (sub_op),
        .operand      (operand),
        .count_src    (count_src),
        .out_valid    (out_valid),
        .out_result   (out_result),
        .out_res_wr   (out_res_wr),
        .out_flag_val (out_flag_val),
        .out_flag_wr  (out_flag_wr),
        .out_illegal  (out_illegal)
    );

    typedef struct packed {
        logic [31:0] res;
        logic        res_wr;
        logic [3:0]  fval;
        logic [3:0]  fwr;
        logic        illegal;
    } exp_t;

    function automatic exp_t model(input logic [2:0] op, input logic [31:0] a,
                                   input logic [31:0] c);
        exp_t e;
        logic [4:0]         n;
        logic [32:0]        ext;
        logic signed [31:0] sa;
        e   = '0;
        n   = c[4:0];
        e.res = a;
        if (op != 3'd4 && op != 3'd5 && op != 3'd7) begin
            e.illegal = 1'b1;
        end else if (n != 0) begin
            e.res_wr = 1'b1;
            e.fwr    = 4'b0011;
            if (op == 3'd4) begin
                ext      = {1'b0, a} << n;
                e.res    = ext[31:0];
                e.fwr[2] = 1'b1;
                e.fval[2] = ext[32];
                e.fval[0] = e.res[31];
            end else if (op == 3'd5) begin
                e.res     = a >> n;
                e.fval[0] = 1'b0;
            end else begin
                sa        = a;
                e.res     = sa >>> n;
                e.fval[0] = e.res[31];
            end
            e.fval[1] = (e.res == 0);
            if (n == 5'd1) begin
                e.fwr[3]  = 1'b1;
                e.fval[3] = (op == 3'd7) ? 1'b0 : (a[31] ^ a[30]);
            end
        end
        return e;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic run_op(input logic [2:0] op, input logic [31:0] a, input logic [31:0] c);
        exp_t e;
        e         = model(op, a, c);
        sub_op    = op;
        operand   = a;
        count_src = c;
        req_valid = 1'b1;
        @(negedge clk);
        chk("R8 out_valid", 32'(out_valid), 32'd1);
        chk("R2 out_illegal", 32'(out_illegal), 32'(e.illegal));
        chk("R7 R2 out_res_wr", 32'(out_res_wr), 32'(e.res_wr));
        chk("R3 R1 out_result", out_result, e.res);
        chk("R4 R5 R6 out_flag_wr", 32'(out_flag_wr), 32'(e.fwr));
        chk("R4 R5 R6 R10 out_flag_val", 32'(out_flag_val), 32'(e.fval));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n     = 1'b0;
        req_valid = 1'b1;
        sub_op    = 3'd4;
        operand   = 32'hFFFF_FFFF;
        count_src = 32'd3;
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9 out_valid", 32'(out_valid), 32'd0);
        chk("R9 out_result", out_result, 32'd0);
        chk("R9 out_flag_wr", 32'(out_flag_wr), 32'd0);
        chk("R9 out_flag_val", 32'(out_flag_val), 32'd0);
        req_valid = 1'b0;
        rst_n     = 1'b1;
        @(negedge clk);

        // R3 examples
        run_op(3'd7, 32'hFFFF_FFFD, 32'd1);
        run_op(3'd5, 32'hFFFF_FFFD, 32'd1);
        run_op(3'd4, 32'd13, 32'd1);
        // R4 carry out of bit 31, R5 overflow for count one
        run_op(3'd4, 32'h8000_0001, 32'd1);
        run_op(3'd4, 32'h4000_0000, 32'd1);
        run_op(3'd4, 32'h0000_0001, 32'd31);
        run_op(3'd4, 32'h0000_0002, 32'd31);
        // R6 right shift flags
        run_op(3'd5, 32'h8000_0000, 32'd31);
        run_op(3'd5, 32'h0000_0001, 32'd1);
        run_op(3'd7, 32'h8000_0000, 32'd31);
        run_op(3'd7, 32'h4000_0000, 32'd1);
        // R1 upper count bits ignored
        run_op(3'd4, 32'h0000_00F0, 32'hFFFF_FFE4);
        run_op(3'd5, 32'h1234_5678, 32'h0000_0020);
        // R7 zero amount
        run_op(3'd7, 32'h8765_4321, 32'd0);
        // R2 illegal codes
        for (int k = 0; k < 8; k++) begin
            if (k != 4 && k != 5 && k != 7) run_op(3'(k), 32'hA5A5_0F0F, 32'd2);
        end
        // R8 idle after a request
        req_valid = 1'b0;
        @(negedge clk);
        chk("R8 idle out_valid", 32'(out_valid), 32'd0);
        chk("R8 idle out_flag_wr", 32'(out_flag_wr), 32'd0);
        chk("R8 idle out_res_wr", 32'(out_res_wr), 32'd0);

        void'($urandom(32'd20240611));
        for (int i = 0; i < 600; i++) begin
            logic [2:0]  op;
            logic [31:0] a;
            logic [31:0] c;
            int          pick;
            pick = int'($urandom_range(0, 9));
            op   = (pick < 3) ? 3'd4 : (pick < 6) ? 3'd5 : (pick < 9) ? 3'd7 : 3'($urandom);
            a    = $urandom;
            c    = (pick % 2 == 0) ? 32'($urandom_range(0, 2)) | ($urandom & 32'hFFFF_FFE0) : $urandom;
            run_op(op, a, c);
            if (i % 50 == 0) begin
                req_valid = 1'b0;
                @(negedge clk);
                chk("R8 gap out_valid", 32'(out_valid), 32'd0);
            end
        end

        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule